// File: doc/BRIEF.md
# Run-Length Configuration Bit Expander

This block turns a compressed byte stream into the serial bit stream that a configuration shifter consumes. Bytes arrive on a valid/ready input port. The block first scans them for a two-byte start marker. Every byte up to and including that marker is consumed and produces no bits.

Once the marker is found, the block sends a fixed 16-bit synchronisation header. It then treats each later byte as one run-length code and expands it into a run of identical bits, which may be followed by one bit of the opposite value. An end-of-stream flag travels with the final byte. When every bit owed by that byte has left the block, the block reports completion.

Back-pressure works on both sides with the usual valid/ready rule: a transfer happens on a rising clock edge where valid and ready are both high. The output holds `out_valid` and `out_bit` steady until `out_ready` takes the bit. The input raises `in_ready` only while no bits are left to send. The upstream source must therefore keep `in_data` and `in_last` steady for as long as `in_valid` is high and `in_ready` is low.

Top module: `rle_bit_expander`

## Requirements
- R1: One cycle after reset is released, `in_ready` is 1, `out_valid` is 0 and `done` is 0.
- R2: The payload begins right after an input byte equal to 0xFF that is directly followed by an input byte whose bits [7:4] equal 0x3. A byte pair such as 0xFF 0x20 is not a marker. In 0xFF 0xFF 0x3X the second 0xFF and the 0x3X form the marker. No byte up to and including the marker produces an output bit.
- R3: When the marker is found, the first 16 output bits are 0xFF20, most significant bit first: eight ones, then 0, 0, 1, 0, 0, 0, 0, 0. The header is sent even when the marker is the final byte.
- R4: A payload code n with 1 <= n <= 226 produces n one-bits followed by one zero-bit.
- R5: Payload code 227 produces 226 one-bits and no terminating bit.
- R6: A payload code n with 228 <= n <= 254 produces n-228 zero-bits followed by one one-bit. Code 228 therefore produces a single one-bit.
- R7: Payload code 255 produces exactly one one-bit.
- R8: Payload code 0 produces no output bits and is consumed.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_bit` stays unchanged on the next cycle.
- R10: `in_ready` and `out_valid` are never 1 in the same cycle. A new code is accepted only after every bit of the previous code has been taken.
- R11: After the byte marked with `in_last` has been accepted and all its bits taken, `done` rises and stays at 1, with `in_ready` and `out_valid` held at 0. A stream that ends without a marker reaches `done` without producing any bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Compressed input byte |
| in_valid | input | 1 | Input byte is valid |
| in_last | input | 1 | Marks the final byte of the stream |
| in_ready | output | 1 | Block accepts a byte on this edge |
| out_bit | output | 1 | Expanded serial bit |
| out_valid | output | 1 | `out_bit` is valid |
| out_ready | input | 1 | Downstream takes the bit on this edge |
| done | output | 1 | Stream fully expanded; held until reset |

## Verification
The assertions check these properties on every cycle:
- the output hold rule under back-pressure;
- the exclusion between accepting a byte and offering a bit;
- that `done` is sticky and leaves both ports quiet;
- that the first sixteen output bits after reset spell the header.

Only the bench scenarios can show the rest:
- that each code class expands to the correct run length and terminator;
- that false markers and overlapping 0xFF bytes are handled;
- that code 0 is silent;
- that a stream without a marker finishes with no output.

// File: rtl/rlx_pkg.sv
package rlx_pkg;
  localparam int CODE_W = 8;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_HDR  = 2'd1,
    ST_RUN  = 2'd2,
    ST_END  = 2'd3
  } rlx_state_e;

  // One decoded code: a repeated leading bit, then an optional single tail bit
  typedef struct packed {
    logic [CODE_W-1:0] lead_len;
    logic              lead_bit;
    logic              tail_en;
    logic              tail_bit;
  } rlx_run_t;
endpackage

// File: rtl/rlx_code_decode.sv
module rlx_code_decode
  import rlx_pkg::*;
#(
  parameter int MAX_ONES = 226
) (
  input  logic [CODE_W-1:0] code,
  output rlx_run_t          run
);
  localparam int CODE_LONG  = MAX_ONES + 1;
  localparam int CODE_ZBASE = MAX_ONES + 2;
  localparam int CODE_TOP   = (1 << CODE_W) - 1;

  always_comb begin
    run = '0;
    if (code == '0) begin
      run = '0;
    end else if (code <= CODE_W'(MAX_ONES)) begin
      run.lead_len = code;
      run.lead_bit = 1'b1;
      run.tail_en  = 1'b1;
      run.tail_bit = 1'b0;
    end else if (code == CODE_W'(CODE_LONG)) begin
      run.lead_len = CODE_W'(MAX_ONES);
      run.lead_bit = 1'b1;
    end else if (code < CODE_W'(CODE_TOP)) begin
      run.lead_len = code - CODE_W'(CODE_ZBASE);
      run.lead_bit = 1'b0;
      run.tail_en  = 1'b1;
      run.tail_bit = 1'b1;
    end else begin
      run.tail_en  = 1'b1;
      run.tail_bit = 1'b1;
    end
  end
endmodule

// File: rtl/rlx_marker_hunt.sv
module rlx_marker_hunt
  import rlx_pkg::*;
#(
  parameter logic [CODE_W-1:0] MARK_LEAD = 8'hFF,
  parameter logic [3:0]        MARK_TAG  = 4'h3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [CODE_W-1:0] data,
  output logic              hit
);
  logic prev_lead_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     prev_lead_q <= 1'b0;
    else if (take)  prev_lead_q <= (data == MARK_LEAD);
  end

  assign hit = prev_lead_q && (data[CODE_W-1:CODE_W-4] == MARK_TAG);
endmodule

// File: rtl/rlx_header_gen.sv
module rlx_header_gen #(
  parameter int               HDR_W       = 16,
  parameter logic [HDR_W-1:0] HDR_PATTERN = 16'hFF20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic bit_o,
  output logic last_o
);
  localparam int IDX_W = (HDR_W > 1) ? $clog2(HDR_W) : 1;

  logic [HDR_W-1:0] hdr_rev;
  logic [IDX_W-1:0] idx_q;

  // Reverse once so the index counts upward from the first bit sent
  for (genvar g = 0; g < HDR_W; g++) begin : g_rev
    assign hdr_rev[g] = HDR_PATTERN[HDR_W-1-g];
  end

  assign last_o = (idx_q == IDX_W'(HDR_W-1));
  assign bit_o  = hdr_rev[idx_q];

  always_ff @(posedge clk) begin
    if (!rst_n)      idx_q <= '0;
    else if (step)   idx_q <= last_o ? '0 : idx_q + IDX_W'(1);
  end
endmodule

// File: rtl/rlx_run_engine.sv
module rlx_run_engine
  import rlx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  rlx_run_t run,
  input  logic     step,
  output logic     busy,
  output logic     bit_o
);
  logic [CODE_W-1:0] lead_cnt_q;
  logic              lead_bit_q;
  logic              tail_pend_q;
  logic              tail_bit_q;
  logic              in_lead;

  assign in_lead = (lead_cnt_q != '0);
  assign busy    = in_lead || tail_pend_q;
  assign bit_o   = in_lead ? lead_bit_q : tail_bit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lead_cnt_q  <= '0;
      lead_bit_q  <= 1'b0;
      tail_pend_q <= 1'b0;
      tail_bit_q  <= 1'b0;
    end else if (load) begin
      lead_cnt_q  <= run.lead_len;
      lead_bit_q  <= run.lead_bit;
      tail_pend_q <= run.tail_en;
      tail_bit_q  <= run.tail_bit;
    end else if (step) begin
      if (in_lead) lead_cnt_q  <= lead_cnt_q - CODE_W'(1);
      else         tail_pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rle_bit_expander.sv
module rle_bit_expander
  import rlx_pkg::*;
#(
  parameter int                MAX_ONES    = 226,
  parameter int                HDR_W       = 16,
  parameter logic [HDR_W-1:0]  HDR_PATTERN = 16'hFF20,
  parameter logic [CODE_W-1:0] MARK_LEAD   = 8'hFF,
  parameter logic [3:0]        MARK_TAG    = 4'h3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic              out_bit,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              done
);
  rlx_state_e st_q, st_d;
  logic       last_q, last_d;
  logic       hit, hdr_bit, hdr_end, busy, run_bit;
  logic       in_fire, out_fire;
  rlx_run_t   run;

  assign in_ready  = (st_q == ST_HUNT) || ((st_q == ST_RUN) && !busy && !last_q);
  assign out_valid = (st_q == ST_HDR) || ((st_q == ST_RUN) && busy);
  assign out_bit   = (st_q == ST_HDR) ? hdr_bit : run_bit;
  assign done      = (st_q == ST_END);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;

  rlx_marker_hunt #(.MARK_LEAD(MARK_LEAD), .MARK_TAG(MARK_TAG)) u_hunt (
    .clk(clk), .rst_n(rst_n),
    .take(in_fire && (st_q == ST_HUNT)),
    .data(in_data), .hit(hit)
  );

  rlx_header_gen #(.HDR_W(HDR_W), .HDR_PATTERN(HDR_PATTERN)) u_hdr (
    .clk(clk), .rst_n(rst_n),
    .step(out_fire && (st_q == ST_HDR)),
    .bit_o(hdr_bit), .last_o(hdr_end)
  );

  rlx_code_decode #(.MAX_ONES(MAX_ONES)) u_dec (
    .code(in_data), .run(run)
  );

  rlx_run_engine u_eng (
    .clk(clk), .rst_n(rst_n),
    .load(in_fire && (st_q == ST_RUN)),
    .run(run),
    .step(out_fire && (st_q == ST_RUN)),
    .busy(busy), .bit_o(run_bit)
  );

  always_comb begin
    st_d   = st_q;
    last_d = last_q;
    case (st_q)
      ST_HUNT: begin
        if (in_fire) begin
          if (hit) begin
            st_d   = ST_HDR;
            last_d = in_last;
          end else if (in_last) begin
            st_d = ST_END;
          end
        end
      end
      ST_HDR: begin
        if (out_fire && hdr_end) st_d = last_q ? ST_END : ST_RUN;
      end
      ST_RUN: begin
        if (in_fire)              last_d = in_last;
        else if (!busy && last_q) st_d   = ST_END;
      end
      default: st_d = ST_END;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      last_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      last_q <= last_d;
    end
  end
endmodule

// File: rtl/rlx_checker.sv
module rlx_checker #(
  parameter int               HDR_W       = 16,
  parameter logic [HDR_W-1:0] HDR_PATTERN = 16'hFF20
) (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic out_bit,
  input logic out_valid,
  input logic out_ready,
  input logic done
);
  localparam int CNT_W = $clog2(HDR_W + 1) + 1;

  logic [CNT_W-1:0] sent_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sent_q <= '0;
    else if (out_valid && out_ready && (sent_q < CNT_W'(HDR_W))) sent_q <= sent_q + CNT_W'(1);
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (in_ready && !out_valid && !done));

  assert_header_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && (sent_q < CNT_W'(HDR_W)))
      |-> (out_bit == HDR_PATTERN[HDR_W-1-int'(sent_q)]));

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

  assert_port_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  assert_done_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!in_ready && !out_valid));
endmodule

bind rle_bit_expander rlx_checker #(.HDR_W(HDR_W), .HDR_PATTERN(HDR_PATTERN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_bit(out_bit),
  .out_valid(out_valid), .out_ready(out_ready), .done(done)
);

// File: tb/sim_rle_bit_expander.sv
`timescale 1ns/1ps
module sim_rle_bit_expander;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic       out_bit;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic       done;

  int n_checks = 0;
  int n_fail = 0;
  int overlap_cnt = 0;
  int ready_pct = 75;
  bit finished = 1'b0;

  logic [7:0] stim[$];
  bit         exp_q[$];
  bit         got_q[$];

  always #2 clk = ~clk;

  rle_bit_expander u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .out_bit(out_bit),
    .out_valid(out_valid), .out_ready(out_ready), .done(done)
  );

  // Sink: random ready, capture bits that will transfer on the next edge
  initial begin
    forever begin
      @(negedge clk);
      out_ready = ($urandom % 100) < ready_pct;
      #1;
      if (rst_n && in_ready && out_valid) overlap_cnt++;
      if (rst_n && out_valid && out_ready) got_q.push_back(out_bit);
    end
  end

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    end
  endtask

  // Expected bits from the requirements: marker search, header, code classes
  task automatic build_expected();
    int start;
    logic [15:0] hdr;
    exp_q.delete();
    start = -1;
    hdr = 16'hFF20;
    for (int i = 1; i < stim.size(); i++) begin
      if (stim[i-1] == 8'hFF && stim[i][7:4] == 4'h3) begin
        start = i;
        break;
      end
    end
    if (start < 0) return;
    for (int k = 15; k >= 0; k--) exp_q.push_back(hdr[k]);
    for (int i = start + 1; i < stim.size(); i++) begin
      int c;
      c = int'(stim[i]);
      if (c == 0) begin
      end else if (c <= 226) begin
        for (int k = 0; k < c; k++) exp_q.push_back(1'b1);
        exp_q.push_back(1'b0);
      end else if (c == 227) begin
        for (int k = 0; k < 226; k++) exp_q.push_back(1'b1);
      end else if (c < 255) begin
        for (int k = 0; k < c - 228; k++) exp_q.push_back(1'b0);
        exp_q.push_back(1'b1);
      end else begin
        exp_q.push_back(1'b1);
      end
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_last = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    got_q.delete();
    overlap_cnt = 0;
  endtask

  task automatic send_byte(logic [7:0] b, bit last, int gap);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_data = b;
    in_last = last;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic run_scenario(string req, int rdy);
    int cyc;
    int mism;
    ready_pct = rdy;
    apply_reset();
    build_expected();
    for (int i = 0; i < stim.size(); i++)
      send_byte(stim[i], i == stim.size() - 1, int'($urandom % 3));
    @(negedge clk);
    in_valid = 1'b0;
    in_last = 1'b0;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    repeat (2) @(negedge clk);
    #1;
    check(done == 1'b1, "R11", "done after stream", int'(done), 1);
    check(!in_ready && !out_valid, "R11", "ports quiet after done",
          int'({in_ready, out_valid}), 0);
    check(overlap_cnt == 0, "R10", "ready and valid together", overlap_cnt, 0);
    check(got_q.size() == exp_q.size(), req, "bit count", got_q.size(), exp_q.size());
    mism = -1;
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++) begin
      if (got_q[i] != exp_q[i]) begin
        mism = i;
        break;
      end
    end
    check(mism < 0, req, "first mismatching bit index", mism, -1);
  endtask

  // Watchdog: a hung run counts as a failure and still prints the summary
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    apply_reset();
    @(negedge clk);
    #1;
    check(in_ready && !out_valid && !done, "R1", "idle after reset",
          int'({in_ready, out_valid, done}), 4);

    // R2: false marker 0xFF 0x20, then overlapping 0xFF 0xFF 0x3A
    stim = '{8'h00, 8'h12, 8'hFF, 8'h20, 8'hFF, 8'hFF, 8'h3A, 8'h02, 8'hFF};
    run_scenario("R2", 80);
    // R4: short and maximum runs of ones
    stim = '{8'hFF, 8'h31, 8'h01, 8'h03, 8'd226};
    run_scenario("R4", 70);
    // R5: long unterminated runs of ones
    stim = '{8'hFF, 8'h30, 8'd227, 8'd227, 8'h01};
    run_scenario("R5", 90);
    // R6: zero runs ending in one, including code 228 and 254
    stim = '{8'hFF, 8'h3F, 8'd228, 8'd229, 8'd254};
    run_scenario("R6", 60);
    // R7: lone ones
    stim = '{8'hFF, 8'h35, 8'hFF, 8'hFF, 8'hFF};
    run_scenario("R7", 100);
    // R8: silent codes, header only
    stim = '{8'hFF, 8'h33, 8'h00, 8'h00, 8'h00};
    run_scenario("R8", 50);
    // R11: no marker, stream ends without bits
    stim = '{8'hFF, 8'hFF, 8'h40, 8'h13, 8'h00};
    run_scenario("R11", 80);
    // R3: marker as final byte still sends the header
    stim = '{8'h7E, 8'hFF, 8'h3C};
    run_scenario("R3", 75);
    // R9: heavy back-pressure on a mixed stream
    stim = '{8'hFF, 8'h31, 8'h04, 8'd230, 8'd227, 8'h00, 8'hFF, 8'h07};
    run_scenario("R9", 15);

    // Random streams mixing all code classes under varied back-pressure
    for (int s = 0; s < 8; s++) begin
      int len;
      int pos;
      stim.delete();
      len = 4 + int'($urandom % 20);
      pos = int'($urandom % 4);
      for (int i = 0; i < pos; i++) stim.push_back(8'($urandom));
      stim.push_back(8'hFF);
      stim.push_back(8'h30 | 8'($urandom % 16));
      for (int i = 0; i < len; i++) stim.push_back(8'($urandom));
      run_scenario("R10", 30 + int'($urandom % 70));
    end

    summary();
    $finish;
  end
endmodule